// File: doc/BRIEF.md
# Segment LCD Control and Status Register

This block is the 8-bit control and status register of a segment LCD controller. Software writes it and reads it back over a simple single-cycle port. Its control bits go straight to the drivers: the controller on/off switch, the low-power waveform select, the voltage-buffer bypass, the external contrast-supply select and blanking. The display timing logic sends a one-cycle frame-start strobe. From that strobe the block issues a one-cycle data-update strobe and sets a start-of-frame interrupt flag. The interrupt request is the flag qualified by a local enable and by a global enable input.

A small frame sequencer sits at the centre and has four states. `ST_OFF` means the controller is disabled. `ST_STD` means the standard waveform is active. `ST_LP_SET` means the low-power waveform is active and the next frame sets the flag. `ST_LP_SKIP` means the low-power waveform is active and the next frame does not set the flag. The transitions are as follows:

- *power-up* goes from `ST_OFF` to `ST_STD` or to `ST_LP_SET` on a write of enable = 1. The written waveform bit picks the target.
- *shutdown* goes from any running state to `ST_OFF` on a write of enable = 0. It does not wait for a frame boundary.
- *std-frame* goes from a running state to `ST_STD` on a frame start while the pending waveform bit is 0. The flag is set.
- *lp-entry* goes from `ST_STD` to `ST_LP_SKIP` on a frame start while the pending waveform bit is 1. The flag is set.
- *lp-set* goes from `ST_LP_SET` to `ST_LP_SKIP` on a frame start. The flag is set.
- *lp-skip* goes from `ST_LP_SKIP` to `ST_LP_SET` on a frame start. The flag is not set.

A write to the waveform bit is held pending, and the active waveform follows it only on a frame start. The bypass, contrast-supply and blanking bits act at once.

Top module: `lcdr_ctrl_reg`

## Requirements
- R1: After reset, `rd_data` reads 8'h00 and every control output, `data_update`, `irq` and `seq_err` are 0. The register layout is as follows:
  - bit 7: enable
  - bit 6: waveform select (1 = low power)
  - bit 5: reserved
  - bit 4: frame flag
  - bit 3: interrupt enable
  - bit 2: buffer bypass
  - bit 1: external contrast supply
  - bit 0: blanking
- R2: Bit 5 always reads 0, whatever is written to it.
- R3: A write with bit 7 = 0 clears `ctl_enable` and `ctl_lowpwr` in the next cycle. From then on, a frame start produces no `data_update` and does not set the flag. This also holds when the disabling write and a frame start fall in the same cycle.
- R4: Written bits 7, 6, 3, 2, 1 and 0 read back in the next cycle. Bits 2, 1 and 0 drive `ctl_buf_off`, `ctl_ext_supply` and `ctl_blank` from the next cycle on. A write of bit 6 while the controller is enabled changes `ctl_lowpwr` only after the next frame start. A write that enables the controller from the off state loads `ctl_lowpwr` from the written bit 6 at once.
- R5: A frame start while the standard waveform is active sets the flag (bit 4). In the next cycle the flag reads 1 and `data_update` is 1 for exactly that one cycle.
- R6: While the low-power waveform is active, frame starts set the flag alternately. Every frame start gives `data_update`. The first frame start after entering low-power mode sets the flag. This holds whether the mode was entered through a waveform change or through a fresh enable.
- R7: A write with bit 4 = 1 clears the flag, and so does `irq_ack` = 1. A write with bit 4 = 0 leaves the flag unchanged.
- R8: If a frame start that sets the flag falls in the same cycle as a clear (a write of bit 4 = 1, or `irq_ack`), the flag ends up 1.
- R9: `irq` is 1 exactly when the flag, bit 3 and `gie` are all 1.
- R10: A write with bit 7 = 1 and bit 1 = 0, while the stored bit 1 is also 0, pulses `seq_err` for the following cycle. The write itself still takes effect. `seq_err` stays 0 if either the old or the new bit 1 is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 8 | Register write value |
| rd_data | output | 8 | Register read value |
| frame_start | input | 1 | One-cycle frame boundary strobe from the timing logic |
| irq_ack | input | 1 | Interrupt vector acknowledge, clears the flag |
| gie | input | 1 | Global interrupt enable |
| irq | output | 1 | Start-of-frame interrupt request |
| data_update | output | 1 | One-cycle display data update strobe |
| ctl_enable | output | 1 | Drivers own the LCD pins |
| ctl_lowpwr | output | 1 | Active waveform is the low-power one |
| ctl_buf_off | output | 1 | Bypass the divider buffers |
| ctl_ext_supply | output | 1 | Internal contrast supply off, external supply used |
| ctl_blank | output | 1 | Blank the display |
| seq_err | output | 1 | Enable written without the contrast-supply bit |

## Verification
Two things can fall in the same cycle: the flag set by a frame start, and a flag clear by write-one or by acknowledge. The bench also lines up a frame start with a disabling write, and a frame start with a waveform change. It provokes each of these by driving the strobe and the write or acknowledge on the same clock edge. It then judges the flag, `data_update` and `ctl_lowpwr` one cycle later, against an expected state it tracks itself. The cadence in low-power mode is judged over a run of frames, with the expected flag computed from the frame index parity.

// File: rtl/lcdr_pkg.sv
package lcdr_pkg;
    localparam int REG_W   = 8;
    localparam int BIT_EN  = 7;
    localparam int BIT_WF  = 6;
    localparam int BIT_RSV = 5;
    localparam int BIT_IF  = 4;
    localparam int BIT_IE  = 3;
    localparam int BIT_BD  = 2;
    localparam int BIT_CCD = 1;
    localparam int BIT_BL  = 0;

    typedef enum logic [1:0] {
        ST_OFF     = 2'd0,
        ST_STD     = 2'd1,
        ST_LP_SET  = 2'd2,
        ST_LP_SKIP = 2'd3
    } frame_st_t;

    typedef struct packed {
        logic en;
        logic wf;
        logic ie;
        logic bd;
        logic ccd;
        logic bl;
    } ctl_t;
endpackage

// File: rtl/lcdr_regfile.sv
module lcdr_regfile
    import lcdr_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [REG_W-1:0] wr_data,
    output ctl_t             ctl_q,
    output logic             seq_err
);
    ctl_t ctl_d;
    logic err_d;

    always_comb begin
        ctl_d = ctl_q;
        err_d = 1'b0;
        if (wr_en) begin
            ctl_d.en  = wr_data[BIT_EN];
            ctl_d.wf  = wr_data[BIT_WF];
            ctl_d.ie  = wr_data[BIT_IE];
            ctl_d.bd  = wr_data[BIT_BD];
            ctl_d.ccd = wr_data[BIT_CCD];
            ctl_d.bl  = wr_data[BIT_BL];
            // supply must be external before or with the enable
            err_d = wr_data[BIT_EN] & ~wr_data[BIT_CCD] & ~ctl_q.ccd;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q   <= '0;
            seq_err <= 1'b0;
        end else begin
            ctl_q   <= ctl_d;
            seq_err <= err_d;
        end
    end
endmodule

// File: rtl/lcdr_frame_fsm.sv
module lcdr_frame_fsm
    import lcdr_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic wr_en,
    input  logic wr_en_bit,
    input  logic wr_wf_bit,
    input  logic wf_pend,
    input  logic frame_start,
    output logic set_req,
    output logic lp_act,
    output logic data_update
);
    frame_st_t st_q, st_d;
    logic      fire;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q        <= ST_OFF;
            data_update <= 1'b0;
        end else begin
            st_q        <= st_d;
            data_update <= fire;
        end
    end

    // next state and per-cycle outputs
    always_comb begin
        st_d    = st_q;
        fire    = 1'b0;
        set_req = 1'b0;
        unique case (st_q)
            ST_OFF: begin
                if (wr_en && wr_en_bit)
                    st_d = wr_wf_bit ? ST_LP_SET : ST_STD;
            end
            ST_STD, ST_LP_SET, ST_LP_SKIP: begin
                if (wr_en && !wr_en_bit) begin
                    st_d = ST_OFF;
                end else if (frame_start) begin
                    fire = 1'b1;
                    if (!wf_pend) begin
                        st_d    = ST_STD;
                        set_req = 1'b1;
                    end else if (st_q == ST_LP_SKIP) begin
                        st_d    = ST_LP_SET;
                    end else begin
                        st_d    = ST_LP_SKIP;
                        set_req = 1'b1;
                    end
                end
            end
            default: st_d = ST_OFF;
        endcase
    end

    assign lp_act = (st_q == ST_LP_SET) || (st_q == ST_LP_SKIP);
endmodule

// File: rtl/lcdr_flag.sv
module lcdr_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic set_req,
    input  logic wr_clr,
    input  logic irq_ack,
    input  logic ie,
    input  logic gie,
    output logic flag,
    output logic irq
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            flag <= 1'b0;
        else if (set_req)
            flag <= 1'b1;
        else if (wr_clr || irq_ack)
            flag <= 1'b0;
    end

    assign irq = flag & ie & gie;
endmodule

// File: rtl/lcdr_ctrl_reg.sv
module lcdr_ctrl_reg
    import lcdr_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [REG_W-1:0] wr_data,
    output logic [REG_W-1:0] rd_data,
    input  logic             frame_start,
    input  logic             irq_ack,
    input  logic             gie,
    output logic             irq,
    output logic             data_update,
    output logic             ctl_enable,
    output logic             ctl_lowpwr,
    output logic             ctl_buf_off,
    output logic             ctl_ext_supply,
    output logic             ctl_blank,
    output logic             seq_err
);
    ctl_t ctl_q;
    logic set_req;
    logic lp_act;
    logic flag;

    lcdr_regfile i_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_data (wr_data),
        .ctl_q   (ctl_q),
        .seq_err (seq_err)
    );

    lcdr_frame_fsm i_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_en       (wr_en),
        .wr_en_bit   (wr_data[BIT_EN]),
        .wr_wf_bit   (wr_data[BIT_WF]),
        .wf_pend     (ctl_q.wf),
        .frame_start (frame_start),
        .set_req     (set_req),
        .lp_act      (lp_act),
        .data_update (data_update)
    );

    lcdr_flag i_flag (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_req (set_req),
        .wr_clr  (wr_en & wr_data[BIT_IF]),
        .irq_ack (irq_ack),
        .ie      (ctl_q.ie),
        .gie     (gie),
        .flag    (flag),
        .irq     (irq)
    );

    always_comb begin
        rd_data          = '0;
        rd_data[BIT_EN]  = ctl_q.en;
        rd_data[BIT_WF]  = ctl_q.wf;
        rd_data[BIT_RSV] = 1'b0;
        rd_data[BIT_IF]  = flag;
        rd_data[BIT_IE]  = ctl_q.ie;
        rd_data[BIT_BD]  = ctl_q.bd;
        rd_data[BIT_CCD] = ctl_q.ccd;
        rd_data[BIT_BL]  = ctl_q.bl;
    end

    assign ctl_enable     = ctl_q.en;
    assign ctl_lowpwr     = lp_act;
    assign ctl_buf_off    = ctl_q.bd;
    assign ctl_ext_supply = ctl_q.ccd;
    assign ctl_blank      = ctl_q.bl;
endmodule

// File: rtl/lcdr_chk.sv
module lcdr_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       wr_en,
    input logic [7:0] wr_data,
    input logic [7:0] rd_data,
    input logic       frame_start,
    input logic       irq_ack,
    input logic       gie,
    input logic       irq,
    input logic       data_update,
    input logic       ctl_enable,
    input logic       ctl_lowpwr,
    input logic       seq_err
);
    a_r2_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
        rd_data[5] == 1'b0);

    a_r3_off_now: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !wr_data[7]) |=> (!ctl_enable && !ctl_lowpwr && !data_update));

    a_r4_wave_held: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_enable && !frame_start && !wr_en) |=> $stable(ctl_lowpwr));

    a_r5_std_sets: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_enable && !ctl_lowpwr && frame_start && !(wr_en && !wr_data[7]))
        |=> (rd_data[4] && data_update));

    a_r8_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_enable && !ctl_lowpwr && frame_start && irq_ack && !wr_en)
        |=> rd_data[4]);

    a_r9_irq_gated: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (gie && rd_data[4] && rd_data[3]));

    a_r10_seq_err: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_data[7] && !wr_data[1] && !rd_data[1]) |=> seq_err);
endmodule

bind lcdr_ctrl_reg lcdr_chk i_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .wr_en       (wr_en),
    .wr_data     (wr_data),
    .rd_data     (rd_data),
    .frame_start (frame_start),
    .irq_ack     (irq_ack),
    .gie         (gie),
    .irq         (irq),
    .data_update (data_update),
    .ctl_enable  (ctl_enable),
    .ctl_lowpwr  (ctl_lowpwr),
    .seq_err     (seq_err)
);

// File: tb/test_lcdr_ctrl_reg.sv
`timescale 1ns/1ps
module test_lcdr_ctrl_reg;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic [7:0] rd_data;
    logic       frame_start = 1'b0;
    logic       irq_ack = 1'b0;
    logic       gie = 1'b1;
    logic       irq, data_update, ctl_enable, ctl_lowpwr;
    logic       ctl_buf_off, ctl_ext_supply, ctl_blank, seq_err;
    int         nchk = 0;
    int         nerr = 0;
    bit         done = 1'b0;

    always #2.5 clk = ~clk;

    lcdr_ctrl_reg i_lcdr_ctrl_reg (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .rd_data(rd_data), .frame_start(frame_start), .irq_ack(irq_ack),
        .gie(gie), .irq(irq), .data_update(data_update),
        .ctl_enable(ctl_enable), .ctl_lowpwr(ctl_lowpwr),
        .ctl_buf_off(ctl_buf_off), .ctl_ext_supply(ctl_ext_supply),
        .ctl_blank(ctl_blank), .seq_err(seq_err)
    );

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        nchk++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic cyc(input logic w, input logic [7:0] d, input logic fs, input logic ak);
        wr_en = w; wr_data = d; frame_start = fs; irq_ack = ak;
        @(posedge clk);
        @(negedge clk);
        wr_en = 1'b0; frame_start = 1'b0; irq_ack = 1'b0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            nerr++;
            $display("FAIL watchdog expired");
            $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 rd_data", rd_data, 8'h00);
        chk("R1 outputs", {irq, data_update, ctl_enable, ctl_lowpwr, ctl_buf_off,
                           ctl_ext_supply, ctl_blank, seq_err}, 8'h00);

        // R2 R4 R10 sweep of every write value from the off state
        for (int v = 0; v < 256; v++) begin
            logic [7:0] b;
            b = v[7:0];
            cyc(1'b1, 8'h00, 1'b0, 1'b0);
            cyc(1'b1, b, 1'b0, 1'b0);
            chk("R2 R4 readback", rd_data, b & 8'hCF);
            chk("R4 direct outputs", {5'd0, ctl_buf_off, ctl_ext_supply, ctl_blank},
                {5'd0, b[2:0]});
            chk("R4 enable load", {6'd0, ctl_enable, ctl_lowpwr}, {6'd0, b[7], b[7] & b[6]});
            chk("R10 seq_err sweep", {7'd0, seq_err}, {7'd0, b[7] & ~b[1]});
        end

        // standard mode: flag every frame
        cyc(1'b1, 8'h00, 1'b0, 1'b0);
        cyc(1'b1, 8'h8A, 1'b0, 1'b0);
        for (int i = 0; i < 4; i++) begin
            cyc(1'b0, 8'h00, 1'b1, 1'b0);
            chk("R5 std flag", {6'd0, rd_data[4], data_update}, 8'h03);
            chk("R9 irq on", {7'd0, irq}, 8'h01);
            cyc(1'b0, 8'h00, 1'b0, 1'b0);
            chk("R5 strobe one cycle", {7'd0, data_update}, 8'h00);
            cyc(1'b1, 8'h9A, 1'b0, 1'b0);
            chk("R7 w1c", {7'd0, rd_data[4]}, 8'h00);
        end

        // R4 deferred waveform change
        cyc(1'b1, 8'hCA, 1'b0, 1'b0);
        chk("R4 pending readback", {7'd0, rd_data[6]}, 8'h01);
        for (int i = 0; i < 3; i++) begin
            cyc(1'b0, 8'h00, 1'b0, 1'b0);
            chk("R4 lowpwr held", {7'd0, ctl_lowpwr}, 8'h00);
        end
        // R6 cadence over frames, first low-power frame sets
        for (int i = 0; i < 6; i++) begin
            cyc(1'b0, 8'h00, 1'b1, 1'b0);
            chk("R4 lowpwr applied", {7'd0, ctl_lowpwr}, 8'h01);
            chk("R6 lp cadence", {6'd0, rd_data[4], data_update},
                {6'd0, (i % 2 == 0) ? 1'b1 : 1'b0, 1'b1});
            cyc(1'b0, 8'h00, 1'b0, 1'b1);
            chk("R7 ack clears", {7'd0, rd_data[4]}, 8'h00);
        end
        // state: next frame sets
        cyc(1'b0, 8'h00, 1'b1, 1'b0);
        chk("R6 set phase", {7'd0, rd_data[4]}, 8'h01);
        cyc(1'b1, 8'hCA, 1'b0, 1'b0);
        chk("R7 write zero keeps", {7'd0, rd_data[4]}, 8'h01);
        cyc(1'b1, 8'hDA, 1'b0, 1'b0);
        chk("R7 w1c lp", {7'd0, rd_data[4]}, 8'h00);
        cyc(1'b0, 8'h00, 1'b1, 1'b0);
        chk("R6 skip phase", {6'd0, rd_data[4], data_update}, 8'h01);
        cyc(1'b0, 8'h00, 1'b1, 1'b0);
        chk("R6 set again", {7'd0, rd_data[4]}, 8'h01);
        cyc(1'b0, 8'h00, 1'b0, 1'b1);
        // phase restart on re-enable (next frame would otherwise skip)
        cyc(1'b1, 8'h02, 1'b0, 1'b0);
        cyc(1'b1, 8'hCA, 1'b0, 1'b0);
        chk("R4 enable loads lp", {7'd0, ctl_lowpwr}, 8'h01);
        cyc(1'b0, 8'h00, 1'b1, 1'b0);
        chk("R6 phase restart", {7'd0, rd_data[4]}, 8'h01);
        cyc(1'b0, 8'h00, 1'b0, 1'b1);
        // now skip phase; step to set phase then collide with w1c
        cyc(1'b0, 8'h00, 1'b1, 1'b0);
        chk("R6 skip after restart", {7'd0, rd_data[4]}, 8'h00);
        cyc(1'b1, 8'hDA, 1'b1, 1'b0);
        chk("R8 lp set beats w1c", {7'd0, rd_data[4]}, 8'h01);
        cyc(1'b0, 8'h00, 1'b0, 1'b1);

        // back to standard
        cyc(1'b1, 8'h8A, 1'b0, 1'b0);
        chk("R4 lp held until frame", {7'd0, ctl_lowpwr}, 8'h01);
        cyc(1'b0, 8'h00, 1'b1, 1'b0);
        chk("R4 std applied", {6'd0, ctl_lowpwr, rd_data[4]}, 8'h01);
        cyc(1'b0, 8'h00, 1'b1, 1'b1);
        chk("R8 set beats ack", {7'd0, rd_data[4]}, 8'h01);
        cyc(1'b1, 8'h9A, 1'b1, 1'b0);
        chk("R8 set beats w1c", {7'd0, rd_data[4]}, 8'h01);

        // R9 gating
        gie = 1'b0;
        #0.1;
        chk("R9 gie off", {7'd0, irq}, 8'h00);
        gie = 1'b1;
        #0.1;
        chk("R9 gie on", {7'd0, irq}, 8'h01);
        cyc(1'b1, 8'h82, 1'b0, 1'b0);
        chk("R9 ie off", {6'd0, rd_data[4], irq}, 8'h02);
        cyc(1'b0, 8'h00, 1'b0, 1'b1);

        // R3 immediate disable
        cyc(1'b1, 8'h02, 1'b0, 1'b0);
        chk("R3 off", {6'd0, ctl_enable, ctl_lowpwr}, 8'h00);
        cyc(1'b0, 8'h00, 1'b1, 1'b0);
        chk("R3 frame ignored", {6'd0, rd_data[4], data_update}, 8'h00);
        cyc(1'b1, 8'h82, 1'b0, 1'b0);
        cyc(1'b1, 8'h02, 1'b1, 1'b0);
        chk("R3 disable beats frame", {5'd0, ctl_enable, rd_data[4], data_update}, 8'h00);

        // R10 sequencing error
        cyc(1'b1, 8'h80, 1'b0, 1'b0);
        chk("R10 old ccd set", {6'd0, ctl_enable, seq_err}, 8'h02);
        cyc(1'b1, 8'h80, 1'b0, 1'b0);
        chk("R10 both zero", {7'd0, seq_err}, 8'h01);
        cyc(1'b0, 8'h00, 1'b0, 1'b0);
        chk("R10 pulse ends", {7'd0, seq_err}, 8'h00);
        cyc(1'b1, 8'h00, 1'b0, 1'b0);
        cyc(1'b1, 8'h82, 1'b0, 1'b0);
        chk("R10 new ccd set", {7'd0, seq_err}, 8'h00);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
        $finish;
    end
endmodule